// File: doc/BRIEF.md
# Routed Multi-Core Interrupt Controller

This block collects a set of interrupt source lines and steers each one toward one of four parent interrupt outputs and one of four processor cores. Every source has its own routing byte. The upper nibble of that byte picks a parent line and the lower nibble picks a core. Each source is also configured on its own as level-sensitive (high or low) or edge-sensitive (rising or falling). Enables are changed through separate set and clear registers, so software never needs a read-modify-write to change them.

Source inputs are synchronized before anything else sees them. A source in edge mode holds its pending bit until software clears it by writing a one to the status register. A source in level mode reports its polarity-corrected level directly. Software reads the raw pending status of all sources, and each core also has its own view that holds only the enabled sources steered to it. The register port is a single-cycle bus with byte lanes. Reads are combinational, and writes take effect at the clock edge.

Top module: `mcore_irq_router`

## Requirements
- R1: After reset the enable mask, polarity, edge and routing registers all read zero, and every parent output is low.
- R2: Source s has a routing byte in byte lane s mod 4 of the word at byte offset 4*(s/4), which covers offsets 0x00 to 0x1F. A write updates only the lanes whose byte enable is set, and a read returns the stored bytes.
- R3: A write to 0x28 sets the enable of every source whose data bit is 1 in an enabled byte lane. A write to 0x2C clears those enables. All other enables keep their value, and 0x24 reads back the current enable mask.
- R4: With edge bit 0 (register 0x34), a source is level-triggered. Polarity bit 1 (register 0x30) makes it active-high and polarity bit 0 makes it active-low. Its pending bit follows the input after the two-flop synchronizer.
- R5: With edge bit 1, polarity 1 captures rising edges and polarity 0 captures falling edges. The captured bit stays set after the input returns and is cleared only by writing 1 to that bit at 0x40. An edge in the same cycle as the clear keeps the bit set.
- R6: Reading 0x40 returns the pending bit of every source, whether the source is enabled or not.
- R7: In a routing byte, bits 7:4 select the parent output: bit 4 selects output 0 and bit 7 selects output 3. Output p is high while an enabled, pending source selects it and has a core bit set. When several parent bits are set, the lowest one is used.
- R8: Bits 3:0 of a routing byte select the core, with bit 0 selecting core 0. When several core bits are set, the lowest one is used. A source with no core bit set drives no output.
- R9: Reading 0x60 + 4*c returns the enabled, pending sources whose selected core is c.
- R10: A disabled source drives no parent output and appears in no core view.
- R11: The start-up sequence, all ones written to 0x2C followed by zero written to 0x34, leaves every source disabled and level-triggered.
- R12: The write-only offsets 0x28 and 0x2C read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| src_in | input | NUM_SRC | Interrupt source lines, asynchronous |
| bus_sel | input | 1 | Register access valid |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Byte address, word-aligned |
| bus_be | input | 4 | Byte lane enables for writes |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data (combinational) |
| irq_out | output | 4 | Parent interrupt outputs |

## Verification
A table drives one routed source through all four trigger modes. Each mode gets an input change that should raise pending and an input change that should not. This separates level-high from level-low and rising from falling, and it separates edge capture from level following. Directed cases then cover the following. A captured edge is held after the input drops. A disabled source still records pending status but drives no output. Routing bytes with several parent bits, several core bits or no core bit show that lowest-bit selection and core gating act on the outputs and on the per-core views.

// File: rtl/irqr_pkg.sv
package irqr_pkg;
  localparam int NUM_OUT  = 4;
  localparam int NUM_CORE = 4;

  localparam logic [7:0] OFS_EN_STAT = 8'h24;
  localparam logic [7:0] OFS_EN_SET  = 8'h28;
  localparam logic [7:0] OFS_EN_CLR  = 8'h2C;
  localparam logic [7:0] OFS_POL     = 8'h30;
  localparam logic [7:0] OFS_EDGE    = 8'h34;
  localparam logic [7:0] OFS_STAT    = 8'h40;
  localparam logic [3:0] OFS_CORE_HI = 4'h6;

  // keep only the lowest set bit of a select nibble
  function automatic logic [3:0] lowest_onehot(input logic [3:0] v);
    return v & (~v + 4'd1);
  endfunction

  // expand byte enables into a 32-bit bit mask
  function automatic logic [31:0] lane_mask(input logic [3:0] be);
    logic [31:0] m;
    for (int i = 0; i < 4; i++) m[8*i +: 8] = {8{be[i]}};
    return m;
  endfunction

  function automatic logic active_level(input logic din, input logic pol);
    return pol ? din : ~din;
  endfunction

  function automatic logic edge_hit(input logic prev, input logic cur, input logic pol);
    return pol ? (~prev & cur) : (prev & ~cur);
  endfunction
endpackage

// File: rtl/irqr_regs.sv
module irqr_regs
  import irqr_pkg::*;
#(
  parameter int NUM_SRC = 32
) (
  input  logic                               clk,
  input  logic                               rst_n,
  input  logic                               bus_sel,
  input  logic                               bus_we,
  input  logic [7:0]                         bus_addr,
  input  logic [3:0]                         bus_be,
  input  logic [31:0]                        bus_wdata,
  output logic [31:0]                        bus_rdata,
  input  logic [NUM_SRC-1:0]                 pending,
  input  logic [NUM_CORE-1:0][NUM_SRC-1:0]   core_view,
  output logic [NUM_SRC-1:0][7:0]            route,
  output logic [NUM_SRC-1:0]                 en,
  output logic [NUM_SRC-1:0]                 pol,
  output logic [NUM_SRC-1:0]                 edg,
  output logic [NUM_SRC-1:0]                 stat_clr
);
  logic                wr;
  logic                wr_set, wr_clr, wr_pol, wr_edge;
  logic [31:0]         wmask32;
  logic [NUM_SRC-1:0]  wmask;
  logic [NUM_SRC-1:0][7:0] route_q;
  logic [NUM_SRC-1:0]  en_q, pol_q, edg_q;

  assign wr      = bus_sel & bus_we;
  assign wr_set  = wr & (bus_addr == OFS_EN_SET);
  assign wr_clr  = wr & (bus_addr == OFS_EN_CLR);
  assign wr_pol  = wr & (bus_addr == OFS_POL);
  assign wr_edge = wr & (bus_addr == OFS_EDGE);
  assign wmask32 = bus_wdata & lane_mask(bus_be);
  assign wmask   = wmask32[NUM_SRC-1:0];
  assign stat_clr = (wr && bus_addr == OFS_STAT) ? wmask : '0;

  generate
    for (genvar s = 0; s < NUM_SRC; s++) begin : g_route
      localparam logic [7:0] WADDR = 8'(4 * (s / 4));
      localparam int         LANE  = s % 4;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
          route_q[s] <= '0;
        else if (wr && bus_addr == WADDR && bus_be[LANE])
          route_q[s] <= bus_wdata[8*LANE +: 8];
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q  <= '0;
      pol_q <= '0;
      edg_q <= '0;
    end else begin
      if (wr_set)       en_q <= en_q | wmask;
      else if (wr_clr)  en_q <= en_q & ~wmask;
      if (wr_pol)  pol_q <= (pol_q & ~lane_mask(bus_be)) | wmask;
      if (wr_edge) edg_q <= (edg_q & ~lane_mask(bus_be)) | wmask;
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (bus_sel) begin
      for (int s = 0; s < NUM_SRC; s++)
        if (bus_addr == 8'(4 * (s / 4))) bus_rdata[8*(s%4) +: 8] = route_q[s];
      case (bus_addr)
        OFS_EN_STAT: bus_rdata = 32'(en_q);
        OFS_POL:     bus_rdata = 32'(pol_q);
        OFS_EDGE:    bus_rdata = 32'(edg_q);
        OFS_STAT:    bus_rdata = 32'(pending);
        default: ;
      endcase
      if (bus_addr[7:4] == OFS_CORE_HI && bus_addr[1:0] == 2'b00)
        bus_rdata = 32'(core_view[bus_addr[3:2]]);
    end
  end

  assign route = route_q;
  assign en    = en_q;
  assign pol   = pol_q;
  assign edg   = edg_q;

  // R3
  en_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_set |=> ((en & $past(wmask)) == $past(wmask)));
  // R3
  en_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_clr |=> ((en & $past(wmask)) == '0));
endmodule

// File: rtl/irqr_detect.sv
module irqr_detect
  import irqr_pkg::*;
#(
  parameter int NUM_SRC = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] src_in,
  input  logic [NUM_SRC-1:0] pol,
  input  logic [NUM_SRC-1:0] edg,
  input  logic [NUM_SRC-1:0] stat_clr,
  output logic [NUM_SRC-1:0] pending
);
  logic [NUM_SRC-1:0] sync1, sync2, prev;
  logic [NUM_SRC-1:0] edge_evt, lvl_act, latch_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync1   <= '0;
      sync2   <= '0;
      prev    <= '0;
      latch_q <= '0;
    end else begin
      sync1   <= src_in;
      sync2   <= sync1;
      prev    <= sync2;
      // a new edge wins over a clear in the same cycle
      latch_q <= edg & ((latch_q & ~stat_clr) | edge_evt);
    end
  end

  generate
    for (genvar s = 0; s < NUM_SRC; s++) begin : g_src
      assign edge_evt[s] = edge_hit(prev[s], sync2[s], pol[s]);
      assign lvl_act[s]  = active_level(sync2[s], pol[s]);
    end
  endgenerate

  assign pending = (edg & latch_q) | (~edg & lvl_act);

  // R5
  edge_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (($past(edge_evt & edg) & edg & ~pending) == '0));
  // R5
  latch_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (($past(pending & edg & ~stat_clr) & edg & ~pending) == '0));
endmodule

// File: rtl/irqr_route.sv
module irqr_route
  import irqr_pkg::*;
#(
  parameter int NUM_SRC = 32
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic [NUM_SRC-1:0][7:0]           route,
  input  logic [NUM_SRC-1:0]                en,
  input  logic [NUM_SRC-1:0]                pending,
  output logic [NUM_OUT-1:0]                irq_out,
  output logic [NUM_CORE-1:0][NUM_SRC-1:0]  core_view
);
  logic [NUM_SRC-1:0]               src_live;
  logic [NUM_OUT-1:0][NUM_SRC-1:0]  to_out;

  generate
    for (genvar s = 0; s < NUM_SRC; s++) begin : g_src
      logic [3:0] psel, csel;
      assign psel        = lowest_onehot(route[s][7:4]);
      assign csel        = lowest_onehot(route[s][3:0]);
      assign src_live[s] = en[s] & pending[s] & (|csel);
      for (genvar p = 0; p < NUM_OUT; p++) begin : g_out
        assign to_out[p][s] = src_live[s] & psel[p];
      end
      for (genvar c = 0; c < NUM_CORE; c++) begin : g_core
        assign core_view[c][s] = src_live[s] & csel[c];
      end
    end
    for (genvar p = 0; p < NUM_OUT; p++) begin : g_or
      assign irq_out[p] = |to_out[p];
    end
  endgenerate

  // R10
  disabled_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en == '0) |-> (irq_out == '0));
  // R7
  out_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_out != '0) |-> ((en & pending) != '0));
endmodule

// File: rtl/mcore_irq_router.sv
module mcore_irq_router
  import irqr_pkg::*;
#(
  parameter int NUM_SRC = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] src_in,
  input  logic               bus_sel,
  input  logic               bus_we,
  input  logic [7:0]         bus_addr,
  input  logic [3:0]         bus_be,
  input  logic [31:0]        bus_wdata,
  output logic [31:0]        bus_rdata,
  output logic [NUM_OUT-1:0] irq_out
);
  logic [NUM_SRC-1:0][7:0]           route;
  logic [NUM_SRC-1:0]                en, pol, edg, stat_clr, pending;
  logic [NUM_CORE-1:0][NUM_SRC-1:0]  core_view;

  irqr_regs #(.NUM_SRC(NUM_SRC)) i_regs (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_be(bus_be), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .pending(pending), .core_view(core_view),
    .route(route), .en(en), .pol(pol), .edg(edg), .stat_clr(stat_clr)
  );

  irqr_detect #(.NUM_SRC(NUM_SRC)) i_detect (
    .clk(clk), .rst_n(rst_n), .src_in(src_in), .pol(pol), .edg(edg),
    .stat_clr(stat_clr), .pending(pending)
  );

  irqr_route #(.NUM_SRC(NUM_SRC)) i_route (
    .clk(clk), .rst_n(rst_n), .route(route), .en(en), .pending(pending),
    .irq_out(irq_out), .core_view(core_view)
  );
endmodule

// File: tb/test_mcore_irq_router.sv
module test_mcore_irq_router;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] src_in = '0;
  logic        bus_sel = 1'b0, bus_we = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [3:0]  bus_be = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [3:0]  irq_out;
  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #2 clk = ~clk;

  mcore_irq_router i_mcore_irq_router (
    .clk(clk), .rst_n(rst_n), .src_in(src_in), .bus_sel(bus_sel),
    .bus_we(bus_we), .bus_addr(bus_addr), .bus_be(bus_be),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_out(irq_out)
  );

  // fields: {polarity, edge, first input, second input, expected pending}
  localparam logic [4:0] VEC [8] = '{
    5'b10011, 5'b10100,   // R4 level high
    5'b00101, 5'b00010,   // R4 level low
    5'b11011, 5'b11100,   // R5 rising
    5'b01101, 5'b01010    // R5 falling
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d, input logic [3:0] be);
    @(negedge clk);
    bus_sel = 1; bus_we = 1; bus_addr = a; bus_wdata = d; bus_be = be;
    @(negedge clk);
    bus_sel = 0; bus_we = 0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_sel = 1; bus_we = 0; bus_addr = a;
    #1 d = bus_rdata;
    bus_sel = 0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    idle(2);
    rst_n = 1;
    idle(1);
    // R1 reset state
    rd(8'h24, d); chk("R1 enable", d, 32'h0);
    rd(8'h00, d); chk("R1 route", d, 32'h0);
    rd(8'h30, d); chk("R1 polarity", d, 32'h0);
    rd(8'h34, d); chk("R1 edge", d, 32'h0);
    chk("R1 irq_out", 32'(irq_out), 32'h0);
    // R6: inputs low, active-low level default -> all pending
    rd(8'h40, d); chk("R6 status at reset", d, 32'hFFFF_FFFF);

    // R3 set/clear enables
    wr(8'h28, 32'h0000_00F0, 4'hF); rd(8'h24, d); chk("R3 set", d, 32'h0000_00F0);
    wr(8'h28, 32'h0000_0003, 4'hF); rd(8'h24, d); chk("R3 set keeps", d, 32'h0000_00F3);
    wr(8'h2C, 32'h0000_0021, 4'hF); rd(8'h24, d); chk("R3 clear", d, 32'h0000_00D2);
    wr(8'h28, 32'hFFFF_FFFF, 4'b0001); rd(8'h24, d); chk("R3 lane", d, 32'h0000_00FF);
    // R12 write-only read zero
    rd(8'h28, d); chk("R12 set reads 0", d, 32'h0);
    rd(8'h2C, d); chk("R12 clr reads 0", d, 32'h0);
    // R11 start-up sequence
    wr(8'h34, 32'hFFFF_FFFF, 4'hF);
    wr(8'h2C, 32'hFFFF_FFFF, 4'hF);
    wr(8'h34, 32'h0, 4'hF);
    rd(8'h24, d); chk("R11 all disabled", d, 32'h0);
    rd(8'h34, d); chk("R11 all level", d, 32'h0);

    // R2 routing bytes by lane
    wr(8'h04, 32'h00AB_0000, 4'b0100); rd(8'h04, d); chk("R2 byte lane", d, 32'h00AB_0000);
    wr(8'h04, 32'h0000_2100, 4'b0010); rd(8'h04, d); chk("R2 second lane", d, 32'h00AB_2100);
    wr(8'h28, 32'h0000_0020, 4'hF);  // enable source 5 (out1, core0)

    // R4/R5 trigger modes on source 5
    for (int k = 0; k < 8; k++) begin
      wr(8'h30, 32'(VEC[k][4]) << 5, 4'hF);
      wr(8'h34, 32'(VEC[k][3]) << 5, 4'hF);
      src_in[5] = VEC[k][2];
      idle(5);
      wr(8'h40, 32'h0000_0020, 4'hF);
      idle(1);
      src_in[5] = VEC[k][1];
      idle(5);
      rd(8'h40, d);
      chk(VEC[k][3] ? "R5 edge pending" : "R4 level pending", 32'(d[5]), 32'(VEC[k][0]));
      chk("R7 out1 follows", 32'(irq_out), 32'(VEC[k][0]) << 1);
    end

    // R5 hold and clear, rising
    wr(8'h30, 32'h0000_0020, 4'hF);
    wr(8'h34, 32'h0000_0020, 4'hF);
    src_in[5] = 0; idle(5);
    wr(8'h40, 32'h0000_0020, 4'hF);
    src_in[5] = 1; idle(5);
    src_in[5] = 0; idle(5);
    rd(8'h40, d); chk("R5 held after input drop", 32'(d[5]), 32'h1);
    wr(8'h40, 32'h0000_0020, 4'hF); idle(1);
    rd(8'h40, d); chk("R5 cleared by write", 32'(d[5]), 32'h0);
    chk("R5 output drops", 32'(irq_out), 32'h0);

    // R10 disabled source records but stays quiet
    wr(8'h2C, 32'h0000_0020, 4'hF);
    src_in[5] = 1; idle(5);
    rd(8'h40, d); chk("R6 disabled still pending", 32'(d[5]), 32'h1);
    chk("R10 no output", 32'(irq_out), 32'h0);
    rd(8'h60, d); chk("R10 not in core view", d, 32'h0);
    wr(8'h28, 32'h0000_0020, 4'hF);
    rd(8'h60, d); chk("R9 core0 view", d, 32'h0000_0020);
    chk("R7 out1 after enable", 32'(irq_out), 32'h2);
    wr(8'h40, 32'h0000_0020, 4'hF); idle(1);

    // R7 several parent bits on source 3, level high
    wr(8'h30, 32'h0000_0028, 4'hF);
    wr(8'h00, 32'hC100_0000, 4'b1000);
    wr(8'h28, 32'h0000_0008, 4'hF);
    src_in[3] = 1; idle(4);
    chk("R7 lowest parent", 32'(irq_out), 32'h4);
    // R8 several core bits
    wr(8'h00, 32'h4C00_0000, 4'b1000); idle(1);
    rd(8'h68, d); chk("R8 lowest core view", d, 32'h0000_0008);
    rd(8'h6C, d); chk("R9 other core empty", d, 32'h0);
    chk("R8 output kept", 32'(irq_out), 32'h4);
    // R8 no core bit
    wr(8'h00, 32'h4000_0000, 4'b1000); idle(1);
    chk("R8 no core no output", 32'(irq_out), 32'h0);
    rd(8'h40, d); chk("R6 still pending", 32'(d[3]), 32'h1);

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule